// File: doc/BRIEF.md
# Narrow-Bus Register Access Adapter

The adapter sits between a host that issues 32-bit register accesses at byte offsets and a peripheral register file whose data path is either 16 bits wide, 32 bits wide, or 32 bits wide on a doubled address stride. For each host access it forms the physical address for the selected bus mode. It then issues one or two beats to a simple request/acknowledge slave. On reads it assembles the 32-bit result.

In 16-bit mode most registers are 16 bits wide. Reads of these registers are zero-extended and writes to them keep only the low half-word. Two fixed groups of registers span two adjacent half-words. The four response registers do this on reads, and the argument, status and mask registers do this on writes. For those accesses the low half-word goes out first, at the translated address. The high half-word follows at that address plus two.

The bus mode is a static strap. It is captured on the first clock edge after reset is released, and changes to it take effect only after the next reset. The host starts an access with a one-cycle `req_i` pulse while `ready_o` is high. It then waits for the one-cycle `done_o` pulse.

Top module: `nba_reg_adapter`

## Requirements
- R1: While `rst_ni` is low, and until the first rising clock edge after its release, `ready_o` is 0. After that edge `ready_o` is 1 and `per_req_o` and `done_o` are 0. `rdata_o` is 0 until the first read completes.
- R2: `mode_i` is captured on the first clock edge after reset release. Encodings are 00 = 32-bit, 01 = 16-bit, 10 = 64-bit stride and 11 = 32-bit. Later changes of `mode_i` have no effect on translation or beat count until the next reset.
- R3: In 32-bit mode every access is a single beat at `per_addr_o` = `addr_i`. The full 32-bit write data is presented, and `rdata_o` takes all 32 bits of `per_rdata_i`.
- R4: In 64-bit-stride mode every access is a single beat at `per_addr_o` = `addr_i` shifted left by one, with full 32-bit data in both directions.
- R5: In 16-bit mode `per_addr_o` = `addr_i` shifted right by one. For registers outside the wide groups, the access is one beat. A read returns `{16'h0, per_rdata_i[15:0]}`. A write presents `{16'h0, wdata_i[15:0]}`, so `per_wdata_o[31:16]` is always 0 in this mode.
- R6: In 16-bit mode a read of offset 0x00C, 0x010, 0x014 or 0x018 takes two beats. The first beat is at address A = offset>>1 and the second at A+2. The result is `{second[15:0], first[15:0]}`. A write to these offsets is a single beat.
- R7: In 16-bit mode a write to offset 0x008, 0x038, 0x03C, 0x040 or 0x044 takes two beats. The first beat carries `wdata_i[15:0]` at A = offset>>1. The second beat carries `wdata_i[31:16]` at A+2, in bits 15:0 of the bus. A read of these offsets is a single beat.
- R8: `ready_o` goes low on the edge that accepts `req_i` and stays low until `done_o` has pulsed for exactly one cycle after the last beat's acknowledge. `per_req_o` stays high with stable address and data until `per_ack_i`. A `req_i` pulse while `ready_o` is low is ignored.
- R9: `rdata_o` changes only during a read access, and it holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Bus mode strap: 00 32-bit, 01 16-bit, 10 64-bit stride |
| req_i | input | 1 | One-cycle access start, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (12) | Logical register byte offset |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Adapter idle and able to accept an access |
| done_o | output | 1 | One-cycle pulse at access completion |
| rdata_o | output | 32 | Assembled read data, held after completion |
| per_req_o | output | 1 | Peripheral beat request |
| per_we_o | output | 1 | Peripheral beat direction |
| per_addr_o | output | AW+1 (13) | Physical peripheral address |
| per_wdata_o | output | 32 | Peripheral write data |
| per_ack_i | input | 1 | Peripheral beat acknowledge, with read data |
| per_rdata_i | input | 32 | Peripheral read data, valid with per_ack_i |

## Verification
A wrong classification of an offset shows up as a missing or extra second beat on the peripheral side, at the edge after the first acknowledge. On reads it also shows as a wrong upper half-word in `rdata_o` at the `done_o` pulse. A corrupted mode register or address path shows on `per_addr_o` in the first request cycle after acceptance. A stuck sequencer state shows within a few cycles as `ready_o` never returning or `done_o` lasting longer than one cycle. A merge register captured at the wrong time shows as a change of `rdata_o` across a write or an idle period.

// File: rtl/nba_pkg.sv
package nba_pkg;
  typedef enum logic [1:0] {
    BUS_W32 = 2'b00,
    BUS_W16 = 2'b01,
    BUS_S64 = 2'b10,
    BUS_RSV = 2'b11
  } bus_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_RSP
  } seq_st_e;

  // registers that span two half-words in narrow mode
  localparam int N_WIDE_RD = 4;
  localparam int N_WIDE_WR = 5;
  localparam logic [15:0] WIDE_RD_OFS [N_WIDE_RD] = '{16'h000C, 16'h0010, 16'h0014, 16'h0018};
  localparam logic [15:0] WIDE_WR_OFS [N_WIDE_WR] = '{16'h0008, 16'h0038, 16'h003C, 16'h0040, 16'h0044};
endpackage

// File: rtl/nba_addr_map.sv
module nba_addr_map
  import nba_pkg::*;
#(
  parameter int AW = 12
) (
  input  bus_mode_e     mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  output logic [AW:0]   phys_lo_o,
  output logic [AW:0]   phys_hi_o,
  output logic          narrow_o,
  output logic          two_beat_o
);
  localparam int PAW = AW + 1;

  logic [15:0]          ofs;
  logic [N_WIDE_RD-1:0] rd_hit;
  logic [N_WIDE_WR-1:0] wr_hit;

  assign ofs = 16'(addr_i);

  for (genvar i = 0; i < N_WIDE_RD; i++) begin : g_rd
    assign rd_hit[i] = (ofs == WIDE_RD_OFS[i]);
  end
  for (genvar i = 0; i < N_WIDE_WR; i++) begin : g_wr
    assign wr_hit[i] = (ofs == WIDE_WR_OFS[i]);
  end

  always_comb begin
    case (mode_i)
      BUS_W16: phys_lo_o = {2'b00, addr_i[AW-1:1]};
      BUS_S64: phys_lo_o = {addr_i, 1'b0};
      default: phys_lo_o = {1'b0, addr_i};
    endcase
  end

  assign phys_hi_o  = phys_lo_o + PAW'(2);
  assign narrow_o   = (mode_i == BUS_W16);
  assign two_beat_o = narrow_o && (we_i ? |wr_hit : |rd_hit);
endmodule

// File: rtl/nba_seq.sv
module nba_seq
  import nba_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic two_beat_i,
  input  logic ack_i,
  output logic ready_o,
  output logic issue_o,
  output logic hi_o,
  output logic cap_lo_o,
  output logic cap_hi_o,
  output logic done_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_LO;
      ST_LO:   if (ack_i) st_d = two_beat_i ? ST_HI : ST_RSP;
      ST_HI:   if (ack_i) st_d = ST_RSP;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign ready_o  = en_i && (st_q == ST_IDLE);
  assign issue_o  = (st_q == ST_LO) || (st_q == ST_HI);
  assign hi_o     = (st_q == ST_HI);
  assign cap_lo_o = (st_q == ST_LO) && ack_i;
  assign cap_hi_o = (st_q == ST_HI) && ack_i;
  assign done_o   = (st_q == ST_RSP);
endmodule

// File: rtl/nba_merge.sv
module nba_merge (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        narrow_i,
  input  logic        rd_i,
  input  logic        cap_lo_i,
  input  logic        cap_hi_i,
  input  logic [31:0] d_i,
  output logic [31:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      if (cap_lo_i)      rdata_o <= narrow_i ? {16'h0000, d_i[15:0]} : d_i;
      else if (cap_hi_i) rdata_o[31:16] <= d_i[15:0];
    end
  end
endmodule

// File: rtl/nba_reg_adapter.sv
module nba_reg_adapter
  import nba_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [31:0]   rdata_o,
  output logic          per_req_o,
  output logic          per_we_o,
  output logic [AW:0]   per_addr_o,
  output logic [31:0]   per_wdata_o,
  input  logic          per_ack_i,
  input  logic [31:0]   per_rdata_i
);
  bus_mode_e     mode_q;
  logic          locked_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q;
  logic          start;
  logic          narrow;
  logic          two_beat;
  logic          hi_sel;
  logic          cap_lo;
  logic          cap_hi;
  logic [AW:0]   phys_lo;
  logic [AW:0]   phys_hi;

  // strap captured once after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= BUS_W32;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      mode_q   <= bus_mode_e'(mode_i);
      locked_q <= 1'b1;
    end
  end

  assign start = req_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  nba_addr_map #(.AW(AW)) u_map (
    .mode_i     (mode_q),
    .addr_i     (addr_q),
    .we_i       (we_q),
    .phys_lo_o  (phys_lo),
    .phys_hi_o  (phys_hi),
    .narrow_o   (narrow),
    .two_beat_o (two_beat)
  );

  nba_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (locked_q),
    .start_i    (start),
    .two_beat_i (two_beat),
    .ack_i      (per_ack_i),
    .ready_o    (ready_o),
    .issue_o    (per_req_o),
    .hi_o       (hi_sel),
    .cap_lo_o   (cap_lo),
    .cap_hi_o   (cap_hi),
    .done_o     (done_o)
  );

  nba_merge u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .narrow_i (narrow),
    .rd_i     (!we_q),
    .cap_lo_i (cap_lo),
    .cap_hi_i (cap_hi),
    .d_i      (per_rdata_i),
    .rdata_o  (rdata_o)
  );

  assign per_we_o   = we_q;
  assign per_addr_o = hi_sel ? phys_hi : phys_lo;

  always_comb begin
    if (!narrow)     per_wdata_o = wdata_q;
    else if (hi_sel) per_wdata_o = {16'h0000, wdata_q[31:16]};
    else             per_wdata_o = {16'h0000, wdata_q[15:0]};
  end
endmodule

// File: rtl/nba_reg_adapter_chk.sv
module nba_reg_adapter_chk #(
  parameter int AW = 12
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        ready_o,
  input logic        done_o,
  input logic [31:0] rdata_o,
  input logic        per_req_o,
  input logic        per_ack_i,
  input logic [AW:0] per_addr_o,
  input logic [31:0] per_wdata_o,
  input logic        narrow
);
  p_hold_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_req_o && !per_ack_i |=> per_req_o && $stable(per_addr_o) && $stable(per_wdata_o));

  p_busy_during_beat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_req_o |-> !ready_o);

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_i |=> !ready_o && !done_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o);

  p_narrow_wdata_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_req_o && narrow |-> per_wdata_o[31:16] == 16'h0000);

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !req_i |=> $stable(rdata_o));
endmodule

bind nba_reg_adapter nba_reg_adapter_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_nba_reg_adapter.sv
`timescale 1ns/1ps
module tb_nba_reg_adapter;
  localparam int AW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic          ready_o, done_o;
  logic [31:0]   rdata_o;
  logic          per_req_o, per_we_o;
  logic [AW:0]   per_addr_o;
  logic [31:0]   per_wdata_o;
  logic          per_ack_i = 1'b0;
  logic [31:0]   per_rdata_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  nba_reg_adapter #(.AW(AW)) dut (.*);

  always #10 clk_i = ~clk_i;

  // slave model: ack after lat waiting cycles, log each beat
  int          lat = 0;
  int          cnt = 0;
  int          log_n = 0;
  logic [AW:0] lg_addr [64];
  logic        lg_we   [64];
  logic [31:0] lg_wd   [64];

  function automatic logic [31:0] slv_data(logic [AW:0] a);
    logic [15:0] a16 = 16'(a);
    return {a16 ^ 16'h5A00, a16 ^ 16'h00C3};
  endfunction

  always @(posedge clk_i) begin
    per_ack_i <= 1'b0;
    if (per_req_o && !per_ack_i) begin
      if (cnt >= lat) begin
        per_ack_i   <= 1'b1;
        per_rdata_i <= slv_data(per_addr_o);
        lg_addr[log_n] <= per_addr_o;
        lg_we[log_n]   <= per_we_o;
        lg_wd[log_n]   <= per_wdata_o;
        log_n <= log_n + 1;
        cnt <= 0;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk_i);
    rst_ni = 1'b0;
    mode_i = m;
    repeat (3) @(negedge clk_i);
    check(ready_o == 1'b0, "R1 ready low in reset", 32'(ready_o), 32'h0);
    rst_ni = 1'b1;
    #1;
    check(ready_o == 1'b0, "R1 ready low before first edge", 32'(ready_o), 32'h0);
    @(negedge clk_i);
    check(ready_o == 1'b1 && per_req_o == 1'b0 && done_o == 1'b0, "R1 idle after capture",
          {29'h0, ready_o, per_req_o, done_o}, 32'h4);
    check(rdata_o == 32'h0, "R1 rdata reset", rdata_o, 32'h0);
  endtask

  // runs one access; returns result and index of first logged beat
  task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                        input bit poke_busy, output logic [31:0] rd, output int first);
    bit busy_ok = 1'b1;
    bit seen = 1'b0;
    first = log_n;
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    if (poke_busy) begin
      req_i = 1'b1; we_i = ~w; addr_i = a ^ 12'h100;
    end else begin
      req_i = 1'b0;
    end
    for (int i = 0; i < 100; i++) begin
      if (done_o) begin seen = 1'b1; break; end
      if (ready_o) busy_ok = 1'b0;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    rd = rdata_o;
    check(seen && busy_ok, "R8 ready low until done", {30'h0, seen, busy_ok}, 32'h3);
    @(negedge clk_i);
    check(!done_o && ready_o, "R8 done single pulse", {30'h0, done_o, ready_o}, 32'h1);
  endtask

  task automatic chk_beat(input int idx, input string req, input logic w,
                          input logic [AW:0] a, input logic [31:0] d);
    check(lg_addr[idx] == a, {req, " beat addr"}, 32'(lg_addr[idx]), 32'(a));
    check(lg_we[idx] == w, {req, " beat dir"}, 32'(lg_we[idx]), 32'(w));
    if (w) check(lg_wd[idx] == d, {req, " beat wdata"}, lg_wd[idx], d);
  endtask

  task automatic t_w32;
    logic [31:0] rd;
    int f;
    do_reset(2'b00);
    lat = 0;
    access(1'b0, 12'h024, '0, 1'b0, rd, f);
    check(log_n - f == 1, "R3 read one beat", 32'(log_n - f), 32'h1);
    chk_beat(f, "R3", 1'b0, 13'h024, '0);
    check(rd == slv_data(13'h024), "R3 read data", rd, slv_data(13'h024));
    access(1'b1, 12'h030, 32'hDEADBEEF, 1'b0, rd, f);
    check(log_n - f == 1, "R3 write one beat", 32'(log_n - f), 32'h1);
    chk_beat(f, "R3", 1'b1, 13'h030, 32'hDEADBEEF);
    check(rd == slv_data(13'h024), "R9 rdata held over write", rd, slv_data(13'h024));
    access(1'b0, 12'h010, '0, 1'b0, rd, f);
    check(log_n - f == 1, "R3 response reg one beat", 32'(log_n - f), 32'h1);
    check(rd == slv_data(13'h010), "R3 response reg data", rd, slv_data(13'h010));
    repeat (4) @(negedge clk_i);
    check(rdata_o == slv_data(13'h010), "R9 rdata held idle", rdata_o, slv_data(13'h010));
  endtask

  task automatic t_s64;
    logic [31:0] rd;
    int f;
    do_reset(2'b10);
    lat = 2;
    access(1'b0, 12'h014, '0, 1'b0, rd, f);
    check(log_n - f == 1, "R4 read one beat", 32'(log_n - f), 32'h1);
    chk_beat(f, "R4", 1'b0, 13'h028, '0);
    check(rd == slv_data(13'h028), "R4 read data", rd, slv_data(13'h028));
    access(1'b1, 12'h044, 32'hCAFE1234, 1'b0, rd, f);
    check(log_n - f == 1, "R4 write one beat", 32'(log_n - f), 32'h1);
    chk_beat(f, "R4", 1'b1, 13'h088, 32'hCAFE1234);
  endtask

  task automatic t_w16_plain;
    logic [31:0] rd;
    int f;
    do_reset(2'b01);
    lat = 1;
    access(1'b0, 12'h024, '0, 1'b0, rd, f);
    check(log_n - f == 1, "R5 read one beat", 32'(log_n - f), 32'h1);
    chk_beat(f, "R5", 1'b0, 13'h012, '0);
    check(rd == {16'h0, slv_data(13'h012)[15:0]}, "R5 zero-extended read", rd, {16'h0, slv_data(13'h012)[15:0]});
    access(1'b1, 12'h030, 32'h1234ABCD, 1'b0, rd, f);
    check(log_n - f == 1, "R5 write one beat", 32'(log_n - f), 32'h1);
    chk_beat(f, "R5", 1'b1, 13'h018, 32'h0000ABCD);
    access(1'b1, 12'h00C, 32'h55667788, 1'b0, rd, f);
    check(log_n - f == 1, "R6 response write one beat", 32'(log_n - f), 32'h1);
    chk_beat(f, "R6", 1'b1, 13'h006, 32'h00007788);
    access(1'b0, 12'h038, '0, 1'b0, rd, f);
    check(log_n - f == 1, "R7 status read one beat", 32'(log_n - f), 32'h1);
    check(rd == {16'h0, slv_data(13'h01C)[15:0]}, "R7 status read data", rd, {16'h0, slv_data(13'h01C)[15:0]});
  endtask

  task automatic t_w16_wide_rd;
    logic [31:0] rd, exp;
    int f;
    logic [AW-1:0] ofs [4] = '{12'h00C, 12'h010, 12'h014, 12'h018};
    do_reset(2'b01);
    for (int i = 0; i < 4; i++) begin
      logic [AW:0] pa;
      lat = i;
      pa = 13'(ofs[i] >> 1);
      access(1'b0, ofs[i], '0, 1'b0, rd, f);
      check(log_n - f == 2, "R6 two beats", 32'(log_n - f), 32'h2);
      chk_beat(f, "R6 low first", 1'b0, pa, '0);
      chk_beat(f + 1, "R6 high second", 1'b0, pa + 13'd2, '0);
      exp = {slv_data(pa + 13'd2)[15:0], slv_data(pa)[15:0]};
      check(rd == exp, "R6 merged read", rd, exp);
    end
  endtask

  task automatic t_w16_wide_wr;
    logic [31:0] rd, d;
    int f;
    logic [AW-1:0] ofs [5] = '{12'h008, 12'h038, 12'h03C, 12'h040, 12'h044};
    do_reset(2'b01);
    for (int i = 0; i < 5; i++) begin
      logic [AW:0] pa;
      lat = (i % 3);
      pa = 13'(ofs[i] >> 1);
      d = 32'hA1B2C3D4 + 32'(i) * 32'h01010101;
      access(1'b1, ofs[i], d, 1'b0, rd, f);
      check(log_n - f == 2, "R7 two beats", 32'(log_n - f), 32'h2);
      chk_beat(f, "R7 low first", 1'b1, pa, {16'h0, d[15:0]});
      chk_beat(f + 1, "R7 high second", 1'b1, pa + 13'd2, {16'h0, d[31:16]});
    end
  endtask

  task automatic t_ignore_busy;
    logic [31:0] rd;
    int f, n;
    do_reset(2'b00);
    lat = 2;
    access(1'b0, 12'h020, '0, 1'b1, rd, f);
    n = log_n;
    check(n - f == 1, "R8 busy request ignored", 32'(n - f), 32'h1);
    check(rd == slv_data(13'h020), "R8 original access intact", rd, slv_data(13'h020));
    repeat (6) @(negedge clk_i);
    check(log_n == n && ready_o && !per_req_o, "R8 no late beat", 32'(log_n - n), 32'h0);
  endtask

  task automatic t_mode_lock;
    logic [31:0] rd;
    int f;
    do_reset(2'b01);
    lat = 0;
    @(negedge clk_i);
    mode_i = 2'b10;
    access(1'b0, 12'h024, '0, 1'b0, rd, f);
    chk_beat(f, "R2 mode held after strap change", 1'b0, 13'h012, '0);
    check(rd == {16'h0, slv_data(13'h012)[15:0]}, "R2 narrow read kept", rd, {16'h0, slv_data(13'h012)[15:0]});
    do_reset(2'b11);
    access(1'b0, 12'h024, '0, 1'b0, rd, f);
    chk_beat(f, "R2 code 11 as 32-bit", 1'b0, 13'h024, '0);
  endtask

  initial begin
    t_w32();
    t_s64();
    t_w16_plain();
    t_w16_wide_rd();
    t_w16_wide_wr();
    t_ignore_busy();
    t_mode_lock();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule